// File: doc/BRIEF.md
# Debug PC Capture Register

This block records the program counter of the instruction that raised a data-memory detection event. Once it has recorded a value, it keeps it for a debugger, which reads it through the debug port or from core software while the core is halted in debug state. The register cannot be written from either side. Its only load path is the detection strobe.

A capture locks the register. A new capture becomes possible only after the core has entered debug state and then left it again. A three-state tracker follows this sequence: armed, locked, and locked-with-entry-seen. It watches the edges of the core's debug-state flag. The core can enter debug state for reasons that have nothing to do with data detection. For that reason, a separate reason bit records whether a capture was pending at the moment of entry. A valid flag shows whether the register holds a capture taken since the last re-arm. Reads made outside debug state return a fixed poison pattern.

Top module: `dbg_pc_capture`

## Requirements
- R1: After reset, `cap_valid_o` and `det_reason_o` are 0, the tracker is armed, and the stored value is zero. A read in debug state right after reset returns 0.
- R2: When armed, a clock edge with `det_evt_i` high loads `pc_i` into the capture register and sets `cap_valid_o` from the next cycle on.
- R3: Once a capture has been taken, further `det_evt_i` pulses leave the stored value unchanged until the tracker re-arms. This holds both inside and outside debug state.
- R4: The tracker re-arms only on a debug exit (flag falling) that follows a debug entry (flag rising) seen after the capture. An exit with no entry seen since the capture does not re-arm it.
- R5: Re-arming clears `cap_valid_o` in the cycle after the exit edge. The stored value is kept and can still be read.
- R6: `rd_data_o` equals the stored value when `rd_en_i` and `dbg_state_i` are both 1. Otherwise it equals the poison parameter `POISON`, which is all ones by default.
- R7: At a debug entry edge, `det_reason_o` is set to 1 if a capture is pending: the tracker is locked, or it is armed with `det_evt_i` high in that same cycle. Otherwise it is set to 0. It is cleared at a debug exit edge and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_i | input | PC_W | Current program counter |
| det_evt_i | input | 1 | Data-detection event strobe |
| dbg_state_i | input | 1 | Core is in debug state |
| rd_en_i | input | 1 | Read strobe from the debug port or software |
| rd_data_o | output | PC_W | Captured PC, or POISON when the read is not allowed |
| cap_valid_o | output | 1 | A capture has been taken since the last re-arm |
| det_reason_o | output | 1 | Data detection was among the reasons for the current debug entry |

## Verification
The bench builds the block with `PC_W` set to 8. This lets it sweep every possible PC value through a complete capture, lock, debug-entry, exit and re-arm cycle. In each pass it writes a different value to check that locking holds, both before debug entry and during debug state. With the default all-ones poison, a stored value of 0xFF cannot be told apart from a blocked read, so the poison checks use reads taken outside debug state, where the expected value is known. Directed sequences cover the remaining cases: a capture taken while already in debug state, an exit with no entry seen since the capture, and an entry for another reason.

// File: rtl/dbg_pc_capture.sv
module dbg_pc_capture #(
  parameter int unsigned PC_W = 32,
  parameter logic [PC_W-1:0] POISON = {PC_W{1'b1}}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pc_i,
  input  logic            det_evt_i,
  input  logic            dbg_state_i,
  input  logic            rd_en_i,
  output logic [PC_W-1:0] rd_data_o,
  output logic            cap_valid_o,
  output logic            det_reason_o
);

  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_LOCKED = 2'd1,
    ST_SEEN   = 2'd2
  } trk_e;

  trk_e            st_q, st_d;
  logic [PC_W-1:0] cap_q;
  logic            dbg_q;
  logic            valid_q;
  logic            reason_q;

  wire enter_w = dbg_state_i & ~dbg_q;
  wire leave_w = ~dbg_state_i & dbg_q;
  wire take_w  = (st_q == ST_ARMED) & det_evt_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_ARMED:  if (det_evt_i) st_d = enter_w ? ST_SEEN : ST_LOCKED;
      ST_LOCKED: if (enter_w)   st_d = ST_SEEN;
      ST_SEEN:   if (leave_w)   st_d = ST_ARMED;
      default:   st_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_ARMED;
      cap_q    <= '0;
      dbg_q    <= 1'b0;
      valid_q  <= 1'b0;
      reason_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      dbg_q <= dbg_state_i;
      if (take_w) cap_q <= pc_i;
      if (take_w)
        valid_q <= 1'b1;
      else if (st_q == ST_SEEN && leave_w)
        valid_q <= 1'b0;
      if (enter_w)
        reason_q <= (st_q == ST_LOCKED) | take_w;
      else if (leave_w)
        reason_q <= 1'b0;
    end
  end

  assign rd_data_o    = (rd_en_i & dbg_state_i) ? cap_q : POISON;
  assign cap_valid_o  = valid_q;
  assign det_reason_o = reason_q;

  AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_valid_o && det_evt_i) |=> cap_valid_o);  // R2
  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_valid_o && det_evt_i) |=> (cap_q == $past(pc_i)));  // R2
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid_o && !leave_w) |=> $stable(cap_q));  // R3
  AST_REARM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_valid_o) |-> $past(leave_w));  // R4
  AST_POISON: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_state_i |-> (rd_data_o == POISON));  // R6
  AST_REASON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    leave_w |=> !det_reason_o);  // R7

endmodule

// File: tb/dbg_pc_capture_bench.sv
module dbg_pc_capture_bench;
  localparam int unsigned W = 8;
  localparam logic [W-1:0] PSN = 8'hFF;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pc = '0;
  logic         det = 1'b0;
  logic         dbg = 1'b0;
  logic         rd = 1'b0;
  logic [W-1:0] rdata;
  logic         valid, reason;
  int           total = 0;
  int           bad = 0;

  dbg_pc_capture #(.PC_W(W)) u_dbg_pc_capture (
    .clk(clk), .rst_n(rst_n), .pc_i(pc), .det_evt_i(det),
    .dbg_state_i(dbg), .rd_en_i(rd), .rd_data_o(rdata),
    .cap_valid_o(valid), .det_reason_o(reason)
  );

  always #5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [W-1:0] v);
    pc = v; det = 1'b1;
    step();
    det = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [W-1:0] exp);
    rd = 1'b1; #1;
    chk(rdata == exp, tag, rdata, exp);
    rd = 1'b0; #1;
    chk(rdata == PSN, {tag, " R6 no-strobe"}, rdata, PSN);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    chk(valid == 1'b0, "R1 valid", valid, 0);
    chk(reason == 1'b0, "R1 reason", reason, 0);
    dbg = 1'b1; step();
    read_chk("R1 stored", 8'h00);
    chk(reason == 1'b0, "R7 entry no capture", reason, 0);
    dbg = 1'b0; step();

    for (int p = 0; p < 256; p++) begin
      pulse(W'(p));
      chk(valid == 1'b1, "R2 valid", valid, 1);
      rd = 1'b1; #1;
      chk(rdata == PSN, "R6 outside debug", rdata, PSN);
      rd = 1'b0;
      pulse(W'(p) ^ 8'h5A);
      dbg = 1'b1; step();
      chk(reason == 1'b1, "R7 entry pending", reason, 1);
      read_chk("R2/R3 capture", W'(p));
      pulse(~W'(p));
      read_chk("R3 locked in debug", W'(p));
      dbg = 1'b0; step();
      chk(valid == 1'b0, "R5 valid cleared", valid, 0);
      chk(reason == 1'b0, "R7 exit clears", reason, 0);
      dbg = 1'b1; step();
      read_chk("R5 value kept", W'(p));
      chk(reason == 1'b0, "R7 other-reason entry", reason, 0);
      dbg = 1'b0; step();
    end

    dbg = 1'b1; step();
    pulse(8'h33);
    chk(valid == 1'b1, "R2 capture in debug", valid, 1);
    chk(reason == 1'b0, "R7 holds mid-debug", reason, 0);
    dbg = 1'b0; step();
    chk(valid == 1'b1, "R4 exit without entry", valid, 1);
    pulse(8'h44);
    dbg = 1'b1; step();
    read_chk("R4 still locked", 8'h33);
    chk(reason == 1'b1, "R7 locked at entry", reason, 1);
    dbg = 1'b0; step();
    chk(valid == 1'b0, "R4 rearm after entry+exit", valid, 0);

    pc = 8'h77; det = 1'b1; dbg = 1'b1;
    step();
    det = 1'b0;
    chk(reason == 1'b1, "R7 same-cycle capture", reason, 1);
    read_chk("R2 same-cycle capture", 8'h77);
    dbg = 1'b0; step();
    chk(valid == 1'b0, "R4 rearm same-cycle", valid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule